// File: doc/BRIEF.md
# Doubleword Time Base Counter

This block keeps a millisecond-resolution time of day for a larger timer subsystem. A 12-bit sub-counter advances once for each pulse on a count-enable input. The pulse is expected at roughly 4.1 MHz, so one full revolution of the sub-counter takes a little less than a millisecond. Each time the sub-counter wraps, a 71-bit unsigned base value grows by 4096. The base is held as two 36-bit words. The high word carries the upper 36 bits. The low word carries the lower 35 bits in data bits [34:0], and its bit [35] is never part of the number.

Software loads the base through a write port. A write throws away the 12 sub-counter positions of the low word. Software reads the base through a read port. A read returns the stored base with the live sub-counter added into the 12 rightmost low-word positions, with the two finest counter bits masked. Both returned words are captured on the same edge, so they always come from one snapshot. A one-cycle strobe marks every wrap, so that interval logic elsewhere can count milliseconds.

Top module: `dword_timebase`

## Requirements
- R1: The sub-counter advances by exactly one on each clock edge where `tick_en` is high, holds otherwise, and wraps from 4095 to 0.
- R2: `ovf_pulse` is high for exactly one cycle, in the cycle right after the edge where the sub-counter wrapped from 4095 to 0, and is low at all other times.
- R3: On the edge where the sub-counter wraps, with no write in that cycle, the stored base increases by 4096 (low-word bit 12 is the unit).
- R4: A carry out of low-word bit 34 goes into high-word bit 0, and an increment from the all-ones 71-bit value gives zero.
- R5: A read request on `rd_en` gives `rd_valid` high for one cycle on the next cycle. The returned words equal the base stored at the request edge plus the sub-counter value at that edge with its bits [1:0] forced to zero. A read does not change the stored base.
- R6: Low-word bit 35 always reads as 0, and the value written to that bit has no effect.
- R7: A write loads `wr_hi` as the high word and `wr_lo[34:12]` as the upper part of the low word, clears low-word bits [11:0], and leaves the sub-counter running undisturbed.
- R8: When a write and a sub-counter wrap happen on the same edge, the written value is stored and that wrap's 4096 increment is lost. `ovf_pulse` still fires.
- R9: A read requested on the same edge as a wrap returns the pre-increment base plus 4092.
- R10: After reset the sub-counter and base are zero, and `rd_valid` and `ovf_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable; one pulse advances the sub-counter by one |
| wr_en | input | 1 | Load the base from `wr_hi` / `wr_lo` |
| wr_hi | input | 36 | High word to load |
| wr_lo | input | 36 | Low word to load; bits [35] and [11:0] are discarded |
| rd_en | input | 1 | Request a read of base plus live sub-counter |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| rd_hi | output | 36 | Returned high word |
| rd_lo | output | 36 | Returned low word; bit 35 is always 0 |
| ovf_pulse | output | 1 | One-cycle strobe after each sub-counter wrap |

## Verification
A sub-counter wrap can coincide with either a write or a read. The bench steers the sub-counter to exactly 4095 with a reference count it keeps itself. It then issues the wrap tick together with a write in one run, and together with a read in another. A collision with a write is judged by a later read, which must show the written words with no 4096 added, along with a strobe that still appears. A collision with a read must return the old base plus 4092, and the read after it must show the increment.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
   // Default geometry of the time base
   localparam int unsigned DTB_WORD_W = 36;  // bits per stored word
   localparam int unsigned DTB_CNT_W  = 12;  // sub-counter width
   localparam int unsigned DTB_HIDE_W = 2;   // sub-counter bits masked on reads

   // Width of the numeric base held in two words (low word loses its top bit)
   function automatic int unsigned dtb_base_w(input int unsigned word_w);
      return 2 * word_w - 1;
   endfunction
endpackage

// File: rtl/dtb_subcount.sv
module dtb_subcount #(
   parameter int unsigned CNT_W = dtb_pkg::DTB_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o,
   output logic             ovf_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   assign wrap_o = tick_en && (cnt_q == {CNT_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (tick_en) cnt_q <= cnt_q + 1'b1;
         ovf_q <= wrap_o;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));          // R1
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(cnt_q));                                // R1
   AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> !ovf_q);                                           // R2
   AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> cnt_q == '0);                                      // R2
endmodule

// File: rtl/dtb_base_reg.sv
module dtb_base_reg #(
   parameter int unsigned WORD_W = dtb_pkg::DTB_WORD_W,
   parameter int unsigned CNT_W  = dtb_pkg::DTB_CNT_W,
   localparam int unsigned BASE_W = dtb_pkg::dtb_base_w(WORD_W),
   localparam int unsigned KEEP_W = WORD_W - 1 - CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_hi,
   input  logic [WORD_W-1:0] wr_lo,
   input  logic              wrap_i,
   output logic [BASE_W-1:0] base_o
);
   localparam logic [BASE_W-1:0] STEP = BASE_W'(1) << CNT_W;

   logic [BASE_W-1:0] base_q;
   logic [BASE_W-1:0] load_val;
   logic              unused_lo_bits;

   // High word whole, low word without its top bit and without the counter field
   assign load_val       = {wr_hi, wr_lo[WORD_W-2:CNT_W], {CNT_W{1'b0}}};
   assign unused_lo_bits = ^{wr_lo[WORD_W-1], wr_lo[CNT_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n)      base_q <= '0;
      else if (wr_en)  base_q <= load_val;
      else if (wrap_i) base_q <= base_q + STEP;
   end

   assign base_o = base_q;

   AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && !wr_en) |=> base_q == $past(base_q) + STEP);      // R3
   AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap_i && !wr_en) |=> $stable(base_q));                    // R5
   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (base_q[CNT_W-1:0] == '0) &&
                (base_q[BASE_W-1:CNT_W] == $past({wr_hi, wr_lo[WORD_W-2:CNT_W]}))); // R7

   initial begin
      AST_KEEP_W: assert (KEEP_W >= 1);                            // R7
   end
endmodule

// File: rtl/dtb_read_port.sv
module dtb_read_port #(
   parameter int unsigned WORD_W = dtb_pkg::DTB_WORD_W,
   parameter int unsigned CNT_W  = dtb_pkg::DTB_CNT_W,
   parameter int unsigned HIDE_W = dtb_pkg::DTB_HIDE_W,
   localparam int unsigned BASE_W = dtb_pkg::dtb_base_w(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [BASE_W-1:0] base_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_hi,
   output logic [WORD_W-1:0] rd_lo
);
   logic [CNT_W-1:0]  vis_cnt;
   logic [BASE_W-1:0] sum;
   logic              vld_q;
   logic [WORD_W-1:0] hi_q;
   logic [WORD_W-1:0] lo_q;

   generate
      if (HIDE_W > 0) begin : g_hide
         logic unused_fine_bits;
         assign vis_cnt          = {cnt_i[CNT_W-1:HIDE_W], {HIDE_W{1'b0}}};
         assign unused_fine_bits = ^cnt_i[HIDE_W-1:0];
      end else begin : g_full
         assign vis_cnt = cnt_i;
      end
   endgenerate

   // Base low field is always zero, so this add only carries above the field
   // when the base itself is nonzero there; a full add keeps it general.
   assign sum = base_i + BASE_W'(vis_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else begin
         vld_q <= rd_en;
         if (rd_en) begin
            hi_q <= sum[BASE_W-1:WORD_W-1];
            lo_q <= {1'b0, sum[WORD_W-2:0]};
         end
      end
   end

   assign rd_valid = vld_q;
   assign rd_hi    = hi_q;
   assign rd_lo    = lo_q;

   AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);                                         // R5
   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);                                       // R5
   AST_RD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !rd_lo[WORD_W-1]);                              // R6

   generate
      if (HIDE_W > 0) begin : g_hide_chk
         AST_RD_FINE: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> rd_lo[HIDE_W-1:0] == '0);                 // R5
      end
   endgenerate
endmodule

// File: rtl/dword_timebase.sv
module dword_timebase #(
   parameter int unsigned WORD_W = dtb_pkg::DTB_WORD_W,
   parameter int unsigned CNT_W  = dtb_pkg::DTB_CNT_W,
   parameter int unsigned HIDE_W = dtb_pkg::DTB_HIDE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_hi,
   input  logic [WORD_W-1:0] wr_lo,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_hi,
   output logic [WORD_W-1:0] rd_lo,
   output logic              ovf_pulse
);
   localparam int unsigned BASE_W = dtb_pkg::dtb_base_w(WORD_W);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("dword_timebase: CNT_W must be at least 2");
      end
      if (CNT_W + 2 > WORD_W) begin : g_bad_word
         $error("dword_timebase: WORD_W too narrow for CNT_W");
      end
      if (HIDE_W >= CNT_W) begin : g_bad_hide
         $error("dword_timebase: HIDE_W must be below CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_w;
   logic              wrap_w;
   logic [BASE_W-1:0] base_w;

   dtb_subcount #(.CNT_W(CNT_W)) i_subcount (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .cnt_o   (cnt_w),
      .wrap_o  (wrap_w),
      .ovf_o   (ovf_pulse)
   );

   dtb_base_reg #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_base_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_hi  (wr_hi),
      .wr_lo  (wr_lo),
      .wrap_i (wrap_w),
      .base_o (base_w)
   );

   dtb_read_port #(.WORD_W(WORD_W), .CNT_W(CNT_W), .HIDE_W(HIDE_W)) i_read_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .base_i   (base_w),
      .cnt_i    (cnt_w),
      .rd_valid (rd_valid),
      .rd_hi    (rd_hi),
      .rd_lo    (rd_lo)
   );

   AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wrap_w) |=> ovf_pulse &&
         (base_w[BASE_W-1:CNT_W] == $past({wr_hi, wr_lo[WORD_W-2:CNT_W]}))); // R8
   AST_WRAP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_w |=> ovf_pulse && (cnt_w == '0));                      // R2
endmodule

// File: tb/test_dword_timebase.sv
module test_dword_timebase;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_en, wr_en, rd_en;
   logic [35:0] wr_hi, wr_lo;
   logic        rd_valid, ovf_pulse;
   logic [35:0] rd_hi, rd_lo;

   dword_timebase i_dword_timebase (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_hi(rd_hi), .rd_lo(rd_lo), .ovf_pulse(ovf_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // Reference model
   logic [70:0] m_base;
   logic [11:0] m_cnt;
   logic [71:0] exp_q[$];
   string       tag_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [71:0] got, input logic [71:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // Monitor: pop expected read results as the design presents them
   always @(negedge clk) begin
      if (rst_n === 1'b1 && rd_valid === 1'b1) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected rd_valid", {rd_hi, rd_lo}, '0);
         end else begin
            logic [71:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({rd_hi, rd_lo} === e, t, "read words", {rd_hi, rd_lo}, e);
         end
      end
   end

   // Driver: one clock cycle of stimulus, model update and strobe check
   task automatic step(input logic tk, input logic wr, input logic [35:0] whi,
                       input logic [35:0] wlo, input logic rd, input string rtag);
      logic [70:0] sum;
      logic        exp_ovf;
      tick_en = tk; wr_en = wr; wr_hi = whi; wr_lo = wlo; rd_en = rd;
      if (rd) begin
         sum = m_base + 71'(m_cnt & 12'hFFC);
         exp_q.push_back({sum[70:35], 1'b0, sum[34:0]});
         tag_q.push_back(rtag);
      end
      exp_ovf = tk && (m_cnt == 12'hFFF);
      if (wr)           m_base = {whi, wlo[34:12], 12'h000};
      else if (exp_ovf) m_base = m_base + 71'h1000;
      if (tk) m_cnt = m_cnt + 12'd1;
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      check(ovf_pulse === exp_ovf, "R2", "ovf_pulse", 72'(ovf_pulse), 72'(exp_ovf));
   endtask

   task automatic tick_to(input logic [11:0] target);
      while (m_cnt != target) step(1'b1, 1'b0, '0, '0, 1'b0, "R1");
   endtask

   task automatic rd(input string t);
      step(1'b0, 1'b0, '0, '0, 1'b1, t);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      wr_hi = '0; wr_lo = '0;
      m_base = '0; m_cnt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      check(rd_valid === 1'b0, "R10", "rd_valid after reset", 72'(rd_valid), 72'(0));
      check(ovf_pulse === 1'b0, "R10", "ovf_pulse after reset", 72'(ovf_pulse), 72'(0));
      rd("R10");
      @(negedge clk);

      // R1, R5: irregular ticks with reads at varied fine counter bits
      for (int i = 0; i < 60; i++)
         step(i % 3 != 0, 1'b0, '0, '0, (i % 7) == 3, "R1");
      rd("R5");
      rd("R5");   // second read with no ticks: same words, base untouched
      // R1: pattern of single ticks between reads exposes the hidden bits
      for (int i = 0; i < 6; i++) begin
         step(1'b1, 1'b0, '0, '0, 1'b0, "R1");
         rd("R5");
      end

      // R7, R6: write with sign bit and counter field set; counter keeps running
      step(1'b1, 1'b1, 36'h123456789, 36'hF_ABCD_E5A5, 1'b0, "R7");
      rd("R7");
      step(1'b1, 1'b0, '0, '0, 1'b1, "R6");

      // R9: read on the wrapping edge, R3: read after it
      tick_to(12'hFFF);
      step(1'b1, 1'b0, '0, '0, 1'b1, "R9");
      rd("R3");

      // R4: carry from low-word bit 34 into the high word
      step(1'b0, 1'b1, 36'h0000000FF, 36'h7_FFFF_F000, 1'b0, "R4");
      tick_to(12'hFFF);
      step(1'b1, 1'b0, '0, '0, 1'b0, "R4");
      rd("R4");

      // R4: full 71-bit wrap to zero
      step(1'b0, 1'b1, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 1'b0, "R4");
      tick_to(12'hFFF);
      step(1'b1, 1'b0, '0, '0, 1'b0, "R4");
      rd("R4");

      // R8: write on the wrapping edge wins, strobe still fires
      tick_to(12'hFFF);
      step(1'b1, 1'b1, 36'hA_5A5A_5A5A, 36'h3_C3C3_CFFF, 1'b0, "R8");
      rd("R8");
      step(1'b1, 1'b0, '0, '0, 1'b1, "R8");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R5", "pending reads", 72'(exp_q.size()), 72'(0));
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule